// File: doc/BRIEF.md
# Flash Buffer Chunk DMA Engine

This block copies one chunk of data between the data buffer of a NAND flash controller and system memory each time software commands it. Software writes a memory address, a buffer address and a byte count through a small 32-bit register port. It then writes a command word whose bit 0 picks the direction. The engine moves the chunk one 32-bit word at a time. It raises its interrupt when the chunk is finished, or when the memory side reports a fault. A page larger than one chunk is moved by software: on each interrupt it clears completion, advances both addresses by the chunk size and issues the command again. The engine never chains chunks by itself.

The memory side is a request stream plus a response channel. A request is a valid/ready handshake carrying a write flag, an address and write data. Once the engine raises `mem_req_valid`, it holds the valid and the payload steady until `mem_req_ready` is seen high at a clock edge. It then keeps exactly one request outstanding until `mem_rsp_valid` arrives. The response has no back-pressure: the engine always accepts it. The flash buffer side has two valid/ready streams, one into the engine and one out of it, both addressed by `fbuf_addr`. Valid and data on the outgoing stream stay stable until ready is taken. `fbuf_addr` stays stable while a word waits on either stream. Either side may stall the engine for any number of cycles.

Top module: `flash_xfer_dma`

## Requirements
- R1: Register offsets are: 0x00 settings, 0x04 memory address, 0x08 buffer address, 0x0C byte count, 0x10 command, 0x14 stop, 0x18 busy, 0x1C completion, 0x20 fault. After reset every readable register reads 0. Settings (bits 1:0), both addresses and the byte count read back what was written.
- R2: Command value 1 (bit 0 set) moves byte count / 4 words from the flash buffer into memory. Word k is read at buffer address + 4k and written at memory address + 4k.
- R3: Command value 0 moves byte count / 4 words from memory into the flash buffer, with the same addressing as R2.
- R4: The busy register bit 0 reads 1 from the cycle after an accepted command until the transfer ends, and 0 otherwise.
- R5: A normal end sets completion to 01. A write of 0 to completion clears it, and a nonzero write leaves it unchanged. `irq` is high exactly while completion is nonzero.
- R6: Settings bit 1 reverses the byte order inside each 32-bit word in both directions. Settings bit 0 is only stored.
- R7: An error response from memory ends the transfer at once. Completion becomes 11, fault bit 0 becomes 1, and no later word is moved. A write of 0 to fault clears it.
- R8: Any write to the stop register aborts an active transfer. Busy reads 0 in the next cycle, completion stays 0, and no further word is moved.
- R9: A command written while busy is 1 is ignored: the running transfer keeps its direction and length.
- R10: A command with a byte count below 4 moves no word and sets completion to 01 without busy rising.
- R11: A raised `mem_req_valid` or `fbuf_out_valid` keeps its payload stable until accepted, unless a stop aborts it.
- R12: The address registers are not changed by a transfer, so software rewrites both for the next chunk and each chunk lands where programmed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr (combinational) |
| mem_req_valid | output | 1 | Memory request valid |
| mem_req_ready | input | 1 | Memory request accepted |
| mem_req_write | output | 1 | 1 = memory write, 0 = memory read |
| mem_req_addr | output | 32 | Memory byte address |
| mem_req_wdata | output | 32 | Memory write data |
| mem_rsp_valid | input | 1 | Memory response valid |
| mem_rsp_rdata | input | 32 | Memory read data |
| mem_rsp_err | input | 1 | Memory error acknowledge |
| fbuf_addr | output | 32 | Flash buffer byte address of the current word |
| fbuf_in_valid | input | 1 | Word from flash buffer valid |
| fbuf_in_ready | output | 1 | Engine takes the word from flash buffer |
| fbuf_in_data | input | 32 | Word from flash buffer |
| fbuf_out_valid | output | 1 | Word to flash buffer valid |
| fbuf_out_ready | input | 1 | Flash buffer takes the word |
| fbuf_out_data | output | 32 | Word to flash buffer |
| irq | output | 1 | Interrupt, high while completion is nonzero |

## Verification
The hardest case to reach from the ports is a stop that lands while a memory response is still outstanding. Once the engine has left, that response must be dropped with no write. The bench stops a long flash-to-memory transfer while both memory and buffer stall at random. It then counts memory writes for many cycles afterwards to show the count is frozen. A fault is forced at one chosen word address, in the middle of a chunk, and the bench proves the words after it were never touched. It also issues a command in the middle of a transfer to show the command is ignored.

// File: rtl/fxd_pkg.sv
package fxd_pkg;

  localparam logic [7:0] OFS_SETTINGS = 8'h00;
  localparam logic [7:0] OFS_MEM_BASE = 8'h04;
  localparam logic [7:0] OFS_BUF_BASE = 8'h08;
  localparam logic [7:0] OFS_BYTES    = 8'h0C;
  localparam logic [7:0] OFS_GO       = 8'h10;
  localparam logic [7:0] OFS_HALT     = 8'h14;
  localparam logic [7:0] OFS_BUSY     = 8'h18;
  localparam logic [7:0] OFS_FINISH   = 8'h1C;
  localparam logic [7:0] OFS_FAULT    = 8'h20;

  // direction: 1 = flash buffer into memory, 0 = memory into flash buffer
  localparam logic DIR_BUF_TO_MEM = 1'b1;

  typedef enum logic [2:0] {
    XS_IDLE,
    XS_BUF_GET,
    XS_MEM_REQ,
    XS_MEM_WAIT,
    XS_BUF_PUT
  } xfer_state_t;

endpackage

// File: rtl/fxd_lane_swap.sv
module fxd_lane_swap #(
  parameter int LANES = 4
) (
  input  logic               en,
  input  logic [8*LANES-1:0] din,
  output logic [8*LANES-1:0] dout
);

  logic [8*LANES-1:0] reversed;

  for (genvar b = 0; b < LANES; b++) begin : g_lane
    assign reversed[8*b +: 8] = din[8*(LANES-1-b) +: 8];
  end

  assign dout = en ? reversed : din;

endmodule

// File: rtl/fxd_regs.sv
module fxd_regs
  import fxd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [7:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  input  logic              busy,
  input  logic              fin,
  input  logic              fin_err,
  output logic [1:0]        settings,
  output logic [ADDR_W-1:0] mem_base,
  output logic [ADDR_W-1:0] buf_base,
  output logic [LEN_W-1:0]  byte_len,
  output logic              go,
  output logic              go_dir,
  output logic              halt,
  output logic [1:0]        finish,
  output logic              fault
);

  logic wr_finish_zero;
  logic wr_fault_zero;

  assign go             = reg_wr && (reg_addr == OFS_GO);
  assign go_dir         = reg_wdata[0];
  assign halt           = reg_wr && (reg_addr == OFS_HALT);
  assign wr_finish_zero = reg_wr && (reg_addr == OFS_FINISH) && (reg_wdata == 32'd0);
  assign wr_fault_zero  = reg_wr && (reg_addr == OFS_FAULT) && (reg_wdata == 32'd0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      settings <= '0;
      mem_base <= '0;
      buf_base <= '0;
      byte_len <= '0;
    end else if (reg_wr) begin
      case (reg_addr)
        OFS_SETTINGS: settings <= reg_wdata[1:0];
        OFS_MEM_BASE: mem_base <= reg_wdata[ADDR_W-1:0];
        OFS_BUF_BASE: buf_base <= reg_wdata[ADDR_W-1:0];
        OFS_BYTES:    byte_len <= reg_wdata[LEN_W-1:0];
        default: ;
      endcase
    end
  end

  // completion status: an end event wins over a clearing write in the same cycle
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      finish <= 2'b00;
      fault  <= 1'b0;
    end else begin
      if (fin)                 finish <= {fin_err, 1'b1};
      else if (wr_finish_zero) finish <= 2'b00;
      if (fin && fin_err)      fault  <= 1'b1;
      else if (wr_fault_zero)  fault  <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = 32'd0;
    case (reg_addr)
      OFS_SETTINGS: reg_rdata = {30'd0, settings};
      OFS_MEM_BASE: reg_rdata = 32'(mem_base);
      OFS_BUF_BASE: reg_rdata = 32'(buf_base);
      OFS_BYTES:    reg_rdata = 32'(byte_len);
      OFS_BUSY:     reg_rdata = {31'd0, busy};
      OFS_FINISH:   reg_rdata = {30'd0, finish};
      OFS_FAULT:    reg_rdata = {31'd0, fault};
      default:      reg_rdata = 32'd0;
    endcase
  end

  AST_CLEAR_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_finish_zero && !fin) |=> (finish == 2'b00)) else $error("finish clear");   // R5
  AST_CLEAR_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fault_zero && !fin) |=> !fault) else $error("fault clear");                // R7

endmodule

// File: rtl/fxd_mover.sv
module fxd_mover
  import fxd_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              go,
  input  logic              go_dir,
  input  logic              halt,
  input  logic              swap_en,
  input  logic [ADDR_W-1:0] mem_base,
  input  logic [ADDR_W-1:0] buf_base,
  input  logic [LEN_W-1:0]  byte_len,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [31:0]       mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_rdata,
  input  logic              mem_rsp_err,
  output logic [ADDR_W-1:0] fbuf_addr,
  input  logic              fbuf_in_valid,
  output logic              fbuf_in_ready,
  input  logic [31:0]       fbuf_in_data,
  output logic              fbuf_out_valid,
  input  logic              fbuf_out_ready,
  output logic [31:0]       fbuf_out_data,
  output logic              busy,
  output logic              fin,
  output logic              fin_err
);

  localparam int WCNT_W = LEN_W - 2;
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(4);

  xfer_state_t       state;
  logic              dir_q;
  logic [ADDR_W-1:0] mem_ptr;
  logic [ADDR_W-1:0] buf_ptr;
  logic [WCNT_W-1:0] left;
  logic [31:0]       hold;
  logic [WCNT_W-1:0] words;
  logic [31:0]       in_sw;
  logic [31:0]       rsp_sw;
  logic              start;
  logic              beat_done;
  logic              last_beat;
  logic              rsp_ok;

  fxd_lane_swap #(.LANES(4)) u_swap_in (
    .en(swap_en), .din(fbuf_in_data), .dout(in_sw)
  );
  fxd_lane_swap #(.LANES(4)) u_swap_rsp (
    .en(swap_en), .din(mem_rsp_rdata), .dout(rsp_sw)
  );

  assign words     = WCNT_W'(byte_len >> 2);
  assign start     = (state == XS_IDLE) && go && !halt;
  assign rsp_ok    = (state == XS_MEM_WAIT) && mem_rsp_valid && !mem_rsp_err;
  assign beat_done = !halt && ((rsp_ok && dir_q == DIR_BUF_TO_MEM) ||
                               (state == XS_BUF_PUT && fbuf_out_ready));
  assign last_beat = (left == WCNT_W'(1));

  assign busy           = (state != XS_IDLE);
  assign mem_req_valid  = (state == XS_MEM_REQ);
  assign mem_req_write  = (dir_q == DIR_BUF_TO_MEM);
  assign mem_req_addr   = mem_ptr;
  assign mem_req_wdata  = hold;
  assign fbuf_addr      = buf_ptr;
  assign fbuf_in_ready  = (state == XS_BUF_GET);
  assign fbuf_out_valid = (state == XS_BUF_PUT);
  assign fbuf_out_data  = hold;

  // sequencing
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state   <= XS_IDLE;
      dir_q   <= 1'b0;
      fin     <= 1'b0;
      fin_err <= 1'b0;
    end else begin
      fin     <= 1'b0;
      fin_err <= 1'b0;
      if (halt) begin
        state <= XS_IDLE;
      end else begin
        case (state)
          XS_IDLE: if (go) begin
            dir_q <= go_dir;
            if (words == '0) fin <= 1'b1;
            else state <= (go_dir == DIR_BUF_TO_MEM) ? XS_BUF_GET : XS_MEM_REQ;
          end
          XS_BUF_GET:  if (fbuf_in_valid) state <= XS_MEM_REQ;
          XS_MEM_REQ:  if (mem_req_ready) state <= XS_MEM_WAIT;
          XS_MEM_WAIT: if (mem_rsp_valid) begin
            if (mem_rsp_err) begin
              state   <= XS_IDLE;
              fin     <= 1'b1;
              fin_err <= 1'b1;
            end else if (dir_q != DIR_BUF_TO_MEM) begin
              state <= XS_BUF_PUT;
            end
          end
          default: ;
        endcase
        if (beat_done) begin
          if (last_beat) begin
            state <= XS_IDLE;
            fin   <= 1'b1;
          end else begin
            state <= (dir_q == DIR_BUF_TO_MEM) ? XS_BUF_GET : XS_MEM_REQ;
          end
        end
      end
    end
  end

  // working pointers and count, loaded from the registers at start
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mem_ptr <= '0;
      buf_ptr <= '0;
      left    <= '0;
    end else if (start) begin
      mem_ptr <= mem_base;
      buf_ptr <= buf_base;
      left    <= words;
    end else if (beat_done) begin
      mem_ptr <= mem_ptr + STEP;
      buf_ptr <= buf_ptr + STEP;
      left    <= left - WCNT_W'(1);
    end
  end

  // data holding register between the two sides
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold <= 32'd0;
    end else if (state == XS_BUF_GET && fbuf_in_valid) begin
      hold <= in_sw;
    end else if (rsp_ok && dir_q != DIR_BUF_TO_MEM) begin
      hold <= rsp_sw;
    end
  end

  AST_MEM_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready && !halt) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_wdata))) else $error("mem hold");   // R11
  AST_BUF_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (fbuf_out_valid && !fbuf_out_ready && !halt) |=>
      (fbuf_out_valid && $stable(fbuf_out_data) && $stable(fbuf_addr))) else $error("buf hold");      // R11
  AST_HALT_IDLES: assert property (@(posedge clk) disable iff (!rst_n)
    halt |=> (!busy && !fin)) else $error("halt");                                                     // R8
  AST_GO_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && go && !halt) |=> $stable(dir_q)) else $error("go while busy");                            // R9

endmodule

// File: rtl/flash_xfer_dma.sv
module flash_xfer_dma #(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [7:0]        reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic              mem_req_write,
  output logic [ADDR_W-1:0] mem_req_addr,
  output logic [31:0]       mem_req_wdata,
  input  logic              mem_rsp_valid,
  input  logic [31:0]       mem_rsp_rdata,
  input  logic              mem_rsp_err,
  output logic [ADDR_W-1:0] fbuf_addr,
  input  logic              fbuf_in_valid,
  output logic              fbuf_in_ready,
  input  logic [31:0]       fbuf_in_data,
  output logic              fbuf_out_valid,
  input  logic              fbuf_out_ready,
  output logic [31:0]       fbuf_out_data,
  output logic              irq
);

  logic              busy, fin, fin_err;
  logic [1:0]        settings;
  logic [ADDR_W-1:0] mem_base, buf_base;
  logic [LEN_W-1:0]  byte_len;
  logic              go, go_dir, halt;
  logic [1:0]        finish;
  logic              fault;

  fxd_regs #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .busy(busy), .fin(fin),
    .fin_err(fin_err), .settings(settings), .mem_base(mem_base),
    .buf_base(buf_base), .byte_len(byte_len), .go(go), .go_dir(go_dir),
    .halt(halt), .finish(finish), .fault(fault)
  );

  fxd_mover #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_mover (
    .clk(clk), .rst_n(rst_n), .go(go), .go_dir(go_dir), .halt(halt),
    .swap_en(settings[1]), .mem_base(mem_base), .buf_base(buf_base),
    .byte_len(byte_len), .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
    .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata),
    .mem_rsp_err(mem_rsp_err), .fbuf_addr(fbuf_addr),
    .fbuf_in_valid(fbuf_in_valid), .fbuf_in_ready(fbuf_in_ready),
    .fbuf_in_data(fbuf_in_data), .fbuf_out_valid(fbuf_out_valid),
    .fbuf_out_ready(fbuf_out_ready), .fbuf_out_data(fbuf_out_data),
    .busy(busy), .fin(fin), .fin_err(fin_err)
  );

  assign irq = |finish;

  AST_END_REPORTED: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(busy) && !$past(halt)) |=> finish[0]) else $error("end not reported");   // R5
  AST_FAULT_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fault) |-> (finish == 2'b11)) else $error("fault without finish");        // R7
  AST_HALT_NO_FINISH: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && busy && finish == 2'b00) |=> (finish == 2'b00)) else $error("halt finish");  // R8

endmodule

// File: tb/tb_flash_xfer_dma.sv
module tb_flash_xfer_dma;

  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'h0;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic        mem_req_valid, mem_req_write;
  logic        mem_req_ready = 1'b0;
  logic [31:0] mem_req_addr, mem_req_wdata;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_rdata = 32'h0;
  logic        mem_rsp_err = 1'b0;
  logic [31:0] fbuf_addr;
  logic        fbuf_in_valid = 1'b0;
  logic        fbuf_in_ready;
  logic [31:0] fbuf_in_data;
  logic        fbuf_out_valid;
  logic        fbuf_out_ready = 1'b0;
  logic [31:0] fbuf_out_data;
  logic        irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_xfer_dma dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_rdata(mem_rsp_rdata), .mem_rsp_err(mem_rsp_err),
    .fbuf_addr(fbuf_addr), .fbuf_in_valid(fbuf_in_valid),
    .fbuf_in_ready(fbuf_in_ready), .fbuf_in_data(fbuf_in_data),
    .fbuf_out_valid(fbuf_out_valid), .fbuf_out_ready(fbuf_out_ready),
    .fbuf_out_data(fbuf_out_data), .irq(irq)
  );

  int checks = 0;
  int errors = 0;

  logic [31:0] mem [256];
  logic [31:0] fb  [256];
  logic [15:0] lfsr = 16'hACE1;
  logic        bp_en = 1'b1;
  logic        err_en = 1'b0;
  logic [31:0] err_addr = 32'h0;
  int          mem_wr_cnt = 0;
  int          fb_wr_cnt = 0;
  int          hs_viol = 0;

  logic        pend = 1'b0;
  logic        p_write, p_err;
  logic [7:0]  p_idx;
  logic [31:0] p_wdata;
  logic        prev_mv = 1'b0, prev_bv = 1'b0, prev_halt = 1'b0;
  logic [31:0] prev_maddr, prev_bdata;

  assign fbuf_in_data = fb[fbuf_addr[9:2]];

  // stall pattern source
  always @(posedge clk) lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};

  // memory model: one request at a time, response one cycle after acceptance
  always @(posedge clk) begin
    mem_rsp_valid <= 1'b0;
    mem_rsp_err   <= 1'b0;
    mem_req_ready <= !(mem_req_valid && mem_req_ready) && (!bp_en || lfsr[1]);
    if (pend) begin
      mem_rsp_valid <= 1'b1;
      mem_rsp_rdata <= mem[p_idx];
      mem_rsp_err   <= p_err;
      if (p_write && !p_err) begin
        mem[p_idx] <= p_wdata;
        mem_wr_cnt <= mem_wr_cnt + 1;
      end
      pend <= 1'b0;
    end else if (mem_req_valid && mem_req_ready) begin
      pend    <= 1'b1;
      p_write <= mem_req_write;
      p_idx   <= mem_req_addr[9:2];
      p_wdata <= mem_req_wdata;
      p_err   <= err_en && (mem_req_addr == err_addr);
    end
  end

  // flash buffer model
  always @(posedge clk) begin
    if (fbuf_in_valid && fbuf_in_ready) fbuf_in_valid <= !bp_en || lfsr[2];
    else if (!fbuf_in_valid)            fbuf_in_valid <= !bp_en || lfsr[2];
    fbuf_out_ready <= !bp_en || lfsr[3];
    if (fbuf_out_valid && fbuf_out_ready) begin
      fb[fbuf_addr[9:2]] <= fbuf_out_data;
      fb_wr_cnt <= fb_wr_cnt + 1;
    end
  end

  // handshake monitor (R11)
  always @(posedge clk) begin
    if (rst_n) begin
      if (prev_mv && !prev_halt && (!mem_req_valid || mem_req_addr != prev_maddr)) hs_viol <= hs_viol + 1;
      if (prev_bv && !prev_halt && (!fbuf_out_valid || fbuf_out_data != prev_bdata)) hs_viol <= hs_viol + 1;
    end
    prev_mv    <= mem_req_valid && !mem_req_ready;
    prev_bv    <= fbuf_out_valid && !fbuf_out_ready;
    prev_maddr <= mem_req_addr;
    prev_bdata <= fbuf_out_data;
    prev_halt  <= reg_wr && reg_addr == 8'h14;
  end

  function automatic logic [31:0] fpat(int i);
    return 32'hC0DE0000 ^ (i * 32'h01030507);
  endfunction
  function automatic logic [31:0] mpat(int i);
    return 32'h3C000000 + (i * 32'h00110011);
  endfunction
  function automatic logic [31:0] sent(int i);
    return 32'hEE000000 | i;
  endfunction
  function automatic logic [31:0] rev(logic [31:0] w);
    return {w[7:0], w[15:8], w[23:16], w[31:24]};
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1;
    d = reg_rdata;
  endtask

  task automatic wait_irq();
    int n = 0;
    while (!irq && n < 5000) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic init_arrays();
    @(negedge clk);
    for (int i = 0; i < 256; i++) begin
      fb[i]  = fpat(i);
      mem[i] = sent(i);
    end
  endtask

  task automatic start(input logic [31:0] cfg, input logic [31:0] dram, input logic [31:0] ext,
                       input logic [31:0] len, input logic [31:0] cmd);
    wr(8'h00, cfg);
    wr(8'h04, dram);
    wr(8'h08, ext);
    wr(8'h0C, len);
    wr(8'h10, cmd);
  endtask

  task automatic t_reset();
    logic [31:0] v;
    for (int a = 0; a <= 8'h20; a += 4) begin
      rd(a[7:0], v);
      check(v == 32'h0, "R1 reset value", v, 32'h0);
    end
    check(irq == 1'b0, "R5 irq after reset", {31'd0, irq}, 32'h0);
  endtask

  task automatic t_readback();
    logic [31:0] v;
    wr(8'h00, 32'h3);        rd(8'h00, v); check(v == 32'h3, "R1 settings readback", v, 32'h3);
    wr(8'h04, 32'h1234_5670); rd(8'h04, v); check(v == 32'h1234_5670, "R1 memory address readback", v, 32'h1234_5670);
    wr(8'h08, 32'h0000_0ABC); rd(8'h08, v); check(v == 32'h0000_0ABC, "R1 buffer address readback", v, 32'h0ABC);
    wr(8'h0C, 32'h0000_0200); rd(8'h0C, v); check(v == 32'h200, "R1 byte count readback", v, 32'h200);
    wr(8'h00, 32'h0);
  endtask

  task automatic t_buf_to_mem();
    logic [31:0] v;
    int bad = 0;
    init_arrays();
    start(0, 32'h000, 32'h000, 32'd512, 32'h1);
    rd(8'h18, v);
    check(v == 32'h1, "R4 busy during transfer", v, 32'h1);
    wait_irq();
    for (int i = 0; i < 128; i++) if (mem[i] !== fpat(i)) bad++;
    check(bad == 0, "R2 flash to memory words", bad, 0);
    check(mem[128] === sent(128), "R2 word past chunk untouched", mem[128], sent(128));
    rd(8'h18, v); check(v == 32'h0, "R4 busy after end", v, 0);
    rd(8'h1C, v); check(v == 32'h1, "R5 completion value", v, 1);
    check(irq == 1'b1, "R5 irq while completion set", {31'd0, irq}, 1);
    wr(8'h1C, 32'h5);
    rd(8'h1C, v); check(v == 32'h1, "R5 nonzero write keeps completion", v, 1);
    wr(8'h1C, 32'h0);
    rd(8'h1C, v); check(v == 32'h0, "R5 completion cleared", v, 0);
    check(irq == 1'b0, "R5 irq drops", {31'd0, irq}, 0);
  endtask

  task automatic t_chain();
    logic [31:0] v;
    int bad = 0;
    // second chunk: software advances both addresses by one chunk
    start(0, 32'h200, 32'h200, 32'd512, 32'h1);
    wait_irq();
    for (int i = 128; i < 256; i++) if (mem[i] !== fpat(i)) bad++;
    check(bad == 0, "R12 second chunk placement", bad, 0);
    rd(8'h04, v); check(v == 32'h200, "R12 memory address register kept", v, 32'h200);
    rd(8'h08, v); check(v == 32'h200, "R12 buffer address register kept", v, 32'h200);
    wr(8'h1C, 0);
  endtask

  task automatic t_mem_to_buf_swap();
    int bad = 0;
    init_arrays();
    @(negedge clk);
    for (int i = 0; i < 256; i++) mem[i] = mpat(i);
    start(32'h3, 32'h000, 32'h000, 32'd256, 32'h0);
    wait_irq();
    for (int i = 0; i < 64; i++) if (fb[i] !== rev(mpat(i))) bad++;
    check(bad == 0, "R3 R6 memory to flash with swap", bad, 0);
    check(fb[64] === fpat(64), "R3 buffer past count untouched", fb[64], fpat(64));
    wr(8'h1C, 0);
  endtask

  task automatic t_buf_to_mem_swap();
    int bad = 0;
    init_arrays();
    start(32'h2, 32'h200, 32'h100, 32'd64, 32'h1);
    wait_irq();
    for (int i = 0; i < 16; i++) if (mem[128+i] !== rev(fpat(64+i))) bad++;
    check(bad == 0, "R6 flash to memory with swap", bad, 0);
    check(mem[144] === sent(144), "R2 word past count untouched", mem[144], sent(144));
    wr(8'h1C, 0);
  endtask

  task automatic t_ignore();
    logic [31:0] v;
    int bad = 0;
    int fbw;
    init_arrays();
    fbw = fb_wr_cnt;
    start(0, 32'h000, 32'h000, 32'd64, 32'h1);
    repeat (6) @(negedge clk);
    wr(8'h0C, 32'd8);
    wr(8'h10, 32'h0);
    rd(8'h18, v); check(v == 32'h1, "R9 still busy after ignored command", v, 1);
    wait_irq();
    for (int i = 0; i < 16; i++) if (mem[i] !== fpat(i)) bad++;
    check(bad == 0, "R9 running transfer kept length and direction", bad, 0);
    check(fb_wr_cnt == fbw, "R9 no flash writes from ignored command", fb_wr_cnt, fbw);
    rd(8'h1C, v); check(v == 32'h1, "R9 single completion", v, 1);
    wr(8'h1C, 0);
  endtask

  task automatic t_error();
    logic [31:0] v;
    int fbw;
    init_arrays();
    @(negedge clk);
    for (int i = 0; i < 256; i++) mem[i] = mpat(i);
    err_en = 1'b1; err_addr = 32'h014;
    fbw = fb_wr_cnt;
    start(0, 32'h000, 32'h000, 32'd64, 32'h0);
    wait_irq();
    rd(8'h1C, v); check(v == 32'h3, "R7 completion on fault", v, 3);
    rd(8'h20, v); check(v == 32'h1, "R7 fault flag", v, 1);
    rd(8'h18, v); check(v == 32'h0, "R7 busy cleared", v, 0);
    check(fb[4] === mpat(4), "R7 word before fault moved", fb[4], mpat(4));
    check(fb[5] === fpat(5), "R7 faulting word not moved", fb[5], fpat(5));
    check(fb[6] === fpat(6), "R7 later word not moved", fb[6], fpat(6));
    check(fb_wr_cnt - fbw == 5, "R7 beats before fault", fb_wr_cnt - fbw, 5);
    err_en = 1'b0;
    wr(8'h20, 0);
    rd(8'h20, v); check(v == 32'h0, "R7 fault cleared", v, 0);
    wr(8'h1C, 0);
  endtask

  task automatic t_stop();
    logic [31:0] v;
    int snap, base;
    init_arrays();
    base = mem_wr_cnt;
    start(0, 32'h000, 32'h000, 32'd512, 32'h1);
    repeat (60) @(negedge clk);
    wr(8'h14, 32'h0);
    rd(8'h18, v); check(v == 32'h0, "R8 busy cleared by stop", v, 0);
    snap = mem_wr_cnt;
    repeat (40) @(negedge clk);
    check(mem_wr_cnt == snap, "R8 no words after stop", mem_wr_cnt, snap);
    check(snap - base < 128, "R8 transfer cut short", snap - base, 128);
    rd(8'h1C, v); check(v == 32'h0, "R8 no completion on stop", v, 0);
    check(irq == 1'b0, "R8 no irq on stop", {31'd0, irq}, 0);
  endtask

  task automatic t_zero();
    logic [31:0] v;
    int mw, fr;
    mw = mem_wr_cnt; fr = fb_wr_cnt;
    start(0, 32'h000, 32'h000, 32'd3, 32'h1);
    rd(8'h18, v); check(v == 32'h0, "R10 busy stays low", v, 0);
    rd(8'h1C, v); check(v == 32'h1, "R10 immediate completion", v, 1);
    repeat (10) @(negedge clk);
    check(mem_wr_cnt == mw && fb_wr_cnt == fr, "R10 no beats", mem_wr_cnt, mw);
    wr(8'h1C, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_readback();
    t_buf_to_mem();
    t_chain();
    t_mem_to_buf_swap();
    t_buf_to_mem_swap();
    t_ignore();
    t_error();
    t_stop();
    repeat (5) @(negedge clk);
    t_zero();
    check(hs_viol == 0, "R11 handshake payload held", hs_viol, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule